// File: doc/BRIEF.md
# Dual Rail Reset Supervisor

This block produces one active-low reset for each of two monitored supply rails. Each rail arrives as a digital undervoltage flag that has already been compared, with hysteresis, outside the block. A reset falls only when the rail has been bad for a whole qualification window, so short glitches are ignored. A reset rises again only after the rail has stayed good for a release delay. A 4-bit select word sets that delay, and both channels use the same setting. Each channel keeps its own timer. A standby-fail input overrides both rails and holds both resets low for as long as it is active.

All timing counts cycles of a 1 MHz clock-enable tick (`tick_us`). Clock cycles without a tick do not advance any timer. Each channel is a four-state machine:

- HOLD: reset low, timer cleared.
- RELEASE: reset low, counting the release delay.
- ACTIVE: reset high.
- QUALIFY: reset high, counting how long the undervoltage has lasted.

The transitions are:

- HOLD to RELEASE when the rail is good and standby-fail is inactive.
- RELEASE to ACTIVE on the tick that completes the delay.
- RELEASE to HOLD on a rail dropout or on standby-fail.
- ACTIVE to QUALIFY when the undervoltage flag is seen.
- QUALIFY to ACTIVE if the flag clears before the window ends.
- QUALIFY to HOLD on the tick that completes the window.
- ACTIVE or QUALIFY to HOLD on standby-fail.

Top module: `dual_rail_reset_sup`

## Requirements
- R1: While the synchronous reset `rst` is high, both outputs are low and both timers are cleared. After `rst` is released with a rail good, that rail's output stays low for the full release delay.
- R2: For the flag `rail_uv[i]`, 1 means the rail is out of range. From ACTIVE, `rst_n[i]` falls at the edge of the 20th tick counted after the edge that first sees the flag. If the flag clears before that tick, `rst_n[i]` stays high.
- R3: From HOLD with the rail good, `rst_n[i]` rises at the edge of the D-th tick counted after the edge that first sees the rail good.
- R4: D = 1000 + 600·N ticks for `dly_sel` = N. N=0 gives 1000 and N=15 gives 10000, and each step in between adds the same amount.
- R5: The two channels have separate timers. A rail's assert and release timing depend only on its own flag, and a bad rail never changes the other output.
- R6: If a rail drops out during its release countdown, the timer clears and the output stays low. The whole delay restarts once the rail is good again.
- R7: While `stby_fail` is 1, both outputs are low, with no wait for a clock edge.
- R8: When `stby_fail` returns to 0, each channel whose rail is good runs its full release delay before it rises. This holds even if `stby_fail` arrived in the very cycle the release would have finished.
- R9: Timers advance only in cycles where `tick_us` is 1. Cycles without a tick add nothing to the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_us | input | 1 | 1 MHz timing clock-enable |
| rail_uv | input | 2 | Per-rail undervoltage flag, 1 = out of range |
| stby_fail | input | 1 | Standby-rail failure, 1 forces both resets low |
| dly_sel | input | 4 | Release-delay select N, shared by both channels |
| rst_n | output | 2 | Per-rail reset outputs, active low |

## Verification
The sharpest collision is `stby_fail` rising in the very cycle that a channel's release countdown reaches its last tick. The bench counts a channel to exactly D−1 ticks, then raises `stby_fail` before edge D. The output must stay low at that edge, and a full new delay of D ticks must follow once `stby_fail` clears. A second overlap is an undervoltage flag that clears in the cycle the qualification window would complete. The bench holds the flag for exactly 20 edges and expects the output never to fall.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Per-channel supervisor states
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,  // reset low, timer idle
        ST_RELEASE = 2'd1,  // reset low, counting release delay
        ST_ACTIVE  = 2'd2,  // reset released
        ST_QUALIFY = 2'd3   // reset released, qualifying a dropout
    } rsv_state_e;

endpackage

// File: rtl/rsv_delay_map.sv
module rsv_delay_map #(
    parameter int SEL_W     = 4,
    parameter int MIN_TICKS = 1000,
    parameter int MAX_TICKS = 10000,
    parameter int CNT_W     = 14
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] ticks_o
);

    // Linear map: lowest code -> MIN_TICKS, highest code -> MAX_TICKS
    localparam int STEPS = (1 << SEL_W) - 1;
    localparam int STEP  = (MAX_TICKS - MIN_TICKS) / STEPS;

    localparam logic [CNT_W-1:0] BASE_V = CNT_W'(MIN_TICKS);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    always_comb begin
        ticks_o = BASE_V + (CNT_W'(sel_i) * STEP_V);
    end

endmodule

// File: rtl/rsv_channel.sv
module rsv_channel
    import rsv_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int ACT_TICKS = 20
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             uv_i,
    input  logic             stby_fail_i,
    input  logic [CNT_W-1:0] dly_ticks_i,
    output logic             rst_n_o
);

    localparam logic [CNT_W-1:0] ACT_LAST = CNT_W'(ACT_TICKS - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    rsv_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             released;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state and timer logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                cnt_d = '0;
                if (!stby_fail_i && !uv_i) begin
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (stby_fail_i || uv_i) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q >= dly_ticks_i - ONE) begin
                        state_d = ST_ACTIVE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            ST_ACTIVE: begin
                cnt_d = '0;
                if (stby_fail_i) begin
                    state_d = ST_HOLD;
                end else if (uv_i) begin
                    state_d = ST_QUALIFY;
                end
            end
            ST_QUALIFY: begin
                if (stby_fail_i) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                end else if (!uv_i) begin
                    state_d = ST_ACTIVE;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q == ACT_LAST) begin
                        state_d = ST_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            default: begin
                state_d = ST_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // Output decode: standby failure overrides without waiting for a clock
    always_comb begin
        released = (state_q == ST_ACTIVE) || (state_q == ST_QUALIFY);
        rst_n_o  = released && !stby_fail_i;
    end

    // R1
    after_reset_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !rst_n_o);

    // R3
    release_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o) |-> ($past(!uv_i) && $past(state_q == ST_RELEASE)));

    // R2
    assert_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(rst_n_o) && !stby_fail_i) |-> ($past(uv_i) || $past(stby_fail_i)));

    // R6
    dropout_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RELEASE && uv_i) |=> (state_q == ST_HOLD && cnt_q == '0));

    // R8
    stby_exit_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(stby_fail_i) |-> !rst_n_o);

    // R9
    no_tick_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RELEASE && !tick_i && !uv_i && !stby_fail_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dual_rail_reset_sup.sv
module dual_rail_reset_sup
    import rsv_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int SEL_W     = 4,
    parameter int MIN_TICKS = 1000,
    parameter int MAX_TICKS = 10000,
    parameter int ACT_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_us,
    input  logic [NUM_CH-1:0] rail_uv,
    input  logic              stby_fail,
    input  logic [SEL_W-1:0]  dly_sel,
    output logic [NUM_CH-1:0] rst_n
);

    localparam int CNT_W = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] dly_ticks;

    // Shared delay setting
    rsv_delay_map #(
        .SEL_W    (SEL_W),
        .MIN_TICKS(MIN_TICKS),
        .MAX_TICKS(MAX_TICKS),
        .CNT_W    (CNT_W)
    ) u_map (
        .sel_i  (dly_sel),
        .ticks_o(dly_ticks)
    );

    // One independent supervisor per rail
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            rsv_channel #(
                .CNT_W    (CNT_W),
                .ACT_TICKS(ACT_TICKS)
            ) u_chan (
                .clk_i      (clk),
                .rst_i      (rst),
                .tick_i     (tick_us),
                .uv_i       (rail_uv[g]),
                .stby_fail_i(stby_fail),
                .dly_ticks_i(dly_ticks),
                .rst_n_o    (rst_n[g])
            );
        end
    endgenerate

endmodule

// File: tb/tb_dual_rail_reset_sup.sv
module tb_dual_rail_reset_sup;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b1;
    logic [1:0] rail_uv = 2'b11;
    logic       stby_fail = 1'b0;
    logic [3:0] dly_sel = 4'd0;
    logic [1:0] rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // delay select -> expected release ticks (R4)
    localparam int NV = 4;
    localparam int SEL_T [NV] = '{0, 1, 5, 15};
    localparam int EXP_T [NV] = '{1000, 1600, 4000, 10000};

    dual_rail_reset_sup dut (
        .clk      (clk),
        .rst      (rst),
        .tick_us  (tick_us),
        .rail_uv  (rail_uv),
        .stby_fail(stby_fail),
        .dly_sel  (dly_sel),
        .rst_n    (rst_n)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        edges(3);
        chk("R1 ch0 in reset", rst_n[0], 1'b0);
        chk("R1 ch1 in reset", rst_n[1], 1'b0);
        @(negedge clk) rail_uv = 2'b00;
        edges(2);
        chk("R1 held by reset", rst_n[0], 1'b0);
        @(negedge clk) rst = 1'b0;
        edges(1000);
        chk("R1 full delay ch0", rst_n[0], 1'b0);
        chk("R1 full delay ch1", rst_n[1], 1'b0);
        edges(1);
        chk("R1 release ch0", rst_n[0], 1'b1);
        chk("R1 release ch1", rst_n[1], 1'b1);

        // R2: sustained dropout asserts on both
        @(negedge clk) rail_uv = 2'b11;
        edges(25);
        chk("R2 ch0 asserted", rst_n[0], 1'b0);
        chk("R2 ch1 asserted", rst_n[1], 1'b0);

        // R4 / R3 / R5: walk the delay table on ch0 while ch1 stays bad
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) begin
                dly_sel = 4'(SEL_T[i]);
                rail_uv = 2'b10;
            end
            edges(EXP_T[i]);
            chk("R4 before delay end", rst_n[0], 1'b0);
            chk("R5 ch1 stays low", rst_n[1], 1'b0);
            edges(1);
            chk("R4 R3 release at delay", rst_n[0], 1'b1);
            @(negedge clk) rail_uv = 2'b11;
            edges(25);
            chk("R2 ch0 back low", rst_n[0], 1'b0);
        end

        // R5: independent channels
        @(negedge clk) begin
            dly_sel = 4'd0;
            rail_uv = 2'b00;
        end
        edges(1001);
        chk("R3 ch0 up", rst_n[0], 1'b1);
        chk("R3 ch1 up", rst_n[1], 1'b1);
        @(negedge clk) rail_uv = 2'b10;
        edges(20);
        chk("R2 ch1 before window", rst_n[1], 1'b1);
        edges(1);
        chk("R2 ch1 at window", rst_n[1], 1'b0);
        chk("R5 ch0 unaffected", rst_n[0], 1'b1);

        // R2: a 20-edge dip on ch0 is ignored
        @(negedge clk) rail_uv = 2'b11;
        edges(20);
        chk("R2 dip still high", rst_n[0], 1'b1);
        @(negedge clk) rail_uv = 2'b10;
        edges(5);
        chk("R2 dip ignored", rst_n[0], 1'b1);

        // R6: dropout during countdown restarts it
        @(negedge clk) rail_uv = 2'b00;
        edges(500);
        chk("R6 mid countdown", rst_n[1], 1'b0);
        @(negedge clk) rail_uv = 2'b10;
        edges(3);
        @(negedge clk) rail_uv = 2'b00;
        edges(1000);
        chk("R6 restarted delay", rst_n[1], 1'b0);
        edges(1);
        chk("R6 release after restart", rst_n[1], 1'b1);

        // R7: standby failure forces both low at once
        @(negedge clk) stby_fail = 1'b1;
        #1;
        chk("R7 ch0 forced", rst_n[0], 1'b0);
        chk("R7 ch1 forced", rst_n[1], 1'b0);
        edges(3);
        chk("R7 ch0 held", rst_n[0], 1'b0);

        // R8: full delay after standby clears
        @(negedge clk) stby_fail = 1'b0;
        edges(1000);
        chk("R8 ch0 delay", rst_n[0], 1'b0);
        chk("R8 ch1 delay", rst_n[1], 1'b0);
        edges(1);
        chk("R8 ch0 release", rst_n[0], 1'b1);
        chk("R8 ch1 release", rst_n[1], 1'b1);

        // R8: standby failure in the cycle the release would complete
        @(negedge clk) rail_uv = 2'b01;
        edges(25);
        @(negedge clk) rail_uv = 2'b00;
        edges(1000);
        @(negedge clk) stby_fail = 1'b1;
        edges(1);
        chk("R8 collision ch0 low", rst_n[0], 1'b0);
        @(negedge clk) stby_fail = 1'b0;
        edges(1000);
        chk("R8 collision full delay", rst_n[0], 1'b0);
        edges(1);
        chk("R8 collision release", rst_n[0], 1'b1);
        chk("R8 ch1 release", rst_n[1], 1'b1);

        // R9: no ticks, no progress
        @(negedge clk) rail_uv = 2'b01;
        edges(25);
        @(negedge clk) begin
            rail_uv = 2'b00;
            tick_us = 1'b0;
        end
        edges(50);
        chk("R9 frozen", rst_n[0], 1'b0);
        @(negedge clk) tick_us = 1'b1;
        edges(999);
        chk("R9 ticks only", rst_n[0], 1'b0);
        edges(1);
        chk("R9 release", rst_n[0], 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule